// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for a memory that accepts one base address and then steps through a burst of four words on its own. A base address is captured on a clock edge when the load/advance strobe is low. On each later enabled edge with the strobe high, the block advances one beat. The two lowest address bits follow the chosen burst order, and the upper bits stay at their loaded value. After the fourth beat the burst wraps back to its base word.

The ordering input picks between two orders. In linear order the low bits count upward modulo four from the base. In interleaved order each beat is the base XOR the beat index. The ordering is taken at load time and kept for the rest of that burst. An active-low clock enable freezes all state. A synchronous reset returns the block to address zero at beat zero.

The beat position is a four-state machine with states ST_BEAT0, ST_BEAT1, ST_BEAT2 and ST_BEAT3. A load moves any state to ST_BEAT0. An advance moves ST_BEAT0 to ST_BEAT1, ST_BEAT1 to ST_BEAT2, ST_BEAT2 to ST_BEAT3, and ST_BEAT3 back to ST_BEAT0 (the wrap). A disabled clock keeps the current state.

Top module: `burst_addr_seq`

## Requirements
- R1: Synchronous reset (rst high at a rising edge, regardless of clock enable) sets addr_out to zero and the beat to zero, so that a following linear advance gives low bits 1.
- R2: With clk_en_n low and adv_ld_n low at a rising edge, addr_out equals addr_in as sampled at that edge, starting from the next cycle.
- R3: With order_sel = 0 (linear) captured at load, successive advances give low bits (base+1), (base+2), (base+3), each modulo 4.
- R4: With order_sel = 1 (interleaved) captured at load, successive advances give low bits base^1, base^2, base^3.
- R5: The fourth advance after a load returns the low bits to the base value, and the sequence then repeats.
- R6: During advances, addr_out bits above bit 1 keep their loaded value.
- R7: With clk_en_n high, an edge changes nothing: addr_out holds, and a load request with a new address is ignored.
- R8: A change of order_sel after a load does not alter the order of the burst in progress.
- R9: A load in the middle of a burst restarts at beat zero with the new base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes state |
| adv_ld_n | input | 1 | Low loads a base address, high advances the burst |
| order_sel | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W (17) | Base address presented for a load |
| addr_out | output | ADDR_W (17) | Current full burst address |

## Verification
The hardest case to reach is a wrap after the burst has crossed the modulo-4 boundary in linear order while the order input is toggling. The stimulus loads a base whose low bits are 2, flips order_sel on every advance, and inserts stall cycles with a conflicting load request between beats. Every output must still follow the order captured at load, and the fifth position must equal the base. Interleaved bursts from several base offsets, and a reload in the middle of a burst, cover the other transitions of the beat machine.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int unsigned OFS_W     = 2;
    localparam int unsigned BURST_LEN = 1 << OFS_W;

    typedef enum logic [OFS_W-1:0] {
        ST_BEAT0 = 2'd0,
        ST_BEAT1 = 2'd1,
        ST_BEAT2 = 2'd2,
        ST_BEAT3 = 2'd3
    } beat_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_t;

endpackage

// File: rtl/burst_order.sv
module burst_order
    import burst_pkg::*;
(
    input  logic [OFS_W-1:0] base_lo,
    input  beat_state_t      beat,
    input  burst_order_t     order,
    output logic [OFS_W-1:0] ofs
);

    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    assign lin_ofs = base_lo + OFS_W'(beat);

    for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
        assign ilv_ofs[b] = base_lo[b] ^ beat[b];
    end

    always_comb begin
        unique case (order)
            ORD_LINEAR:     ofs = lin_ofs;
            ORD_INTERLEAVE: ofs = ilv_ofs;
            default:        ofs = lin_ofs;
        endcase
    end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        load,
    output beat_state_t beat
);

    beat_state_t state_q;
    beat_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BEAT0;
        end else if (en) begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_BEAT0;
        end else begin
            unique case (state_q)
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_BEAT0;
            endcase
        end
    end

    assign beat = state_q;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && !load && state_q == ST_BEAT3) |=> (state_q == ST_BEAT0)); // R5
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> (state_q == ST_BEAT0)); // R9

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic              order_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base,
    output burst_order_t      order
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base  <= '0;
            order <= ORD_LINEAR;
        end else if (en && load) begin
            base  <= addr_in;
            order <= burst_order_t'(order_in);
        end
    end

    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!(en && load)) |=> $stable(order)); // R8

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              adv_ld_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int unsigned HI_W = ADDR_W - OFS_W;

    logic             en;
    logic             load;
    logic [ADDR_W-1:0] base;
    burst_order_t     order;
    beat_state_t      beat;
    logic [OFS_W-1:0] ofs;

    assign en   = !clk_en_n;
    assign load = !adv_ld_n;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .load     (load),
        .order_in (order_sel),
        .addr_in  (addr_in),
        .base     (base),
        .order    (order)
    );

    burst_beat_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .load (load),
        .beat (beat)
    );

    burst_order u_order (
        .base_lo (base[OFS_W-1:0]),
        .beat    (beat),
        .order   (order),
        .ofs     (ofs)
    );

    assign addr_out = {base[ADDR_W-1:OFS_W], ofs};

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> (addr_out == $past(addr_in))); // R2
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(addr_out)); // R7
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> (addr_out[ADDR_W-1:OFS_W] == $past(addr_out[ADDR_W-1:OFS_W]))); // R6
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> (addr_out[OFS_W-1:0] != $past(addr_out[OFS_W-1:0]))); // R3

    initial begin
        assert (HI_W >= 1) else $error("address too narrow");
    end

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int unsigned AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b1;
    logic          adv_ld_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;
    bit            m_ilv  = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk       (clk),
        .rst       (rst),
        .clk_en_n  (clk_en_n),
        .adv_ld_n  (adv_ld_n),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        logic [1:0] bt;
        bt = 2'(m_beat);
        lo = m_ilv ? (m_base[1:0] ^ bt) : (m_base[1:0] + bt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic step(input bit r, input bit ce_n, input bit ld_n,
                        input bit ord, input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        rst = r; clk_en_n = ce_n; adv_ld_n = ld_n; order_sel = ord; addr_in = a;
        if (r) begin
            m_base = '0; m_beat = 0; m_ilv = 1'b0;
        end else if (!ce_n) begin
            if (!ld_n) begin
                m_base = a; m_beat = 0; m_ilv = ord;
            end else begin
                m_beat = (m_beat + 1) % 4;
            end
        end
        exp_q.push_back(model_addr());
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [AW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (addr_out !== e) begin
                    errors++;
                    $display("FAIL %s addr_out=%h expected=%h", t, addr_out, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        // R1: reset, also with clock enable high
        step(1, 1, 1, 0, 17'h1FFFF, "R1");
        step(1, 0, 0, 1, 17'h12345, "R1");
        step(0, 0, 1, 0, '0, "R1");          // advance from beat 0 of base 0 -> 1
        // R2/R3/R5/R6: linear, base low bits 2, upper bits nonzero
        step(0, 0, 0, 0, 17'h1A5B6, "R2");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 17'h00000, "R3");
        step(0, 0, 1, 0, 17'h0FFFF, "R5");
        step(0, 0, 1, 0, 17'h00000, "R6");
        // R4/R5: interleaved from base low bits 1 and 3
        step(0, 0, 0, 1, 17'h0C3D1, "R2");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, '0, "R4");
        step(0, 0, 1, 1, '0, "R5");
        step(0, 0, 0, 1, 17'h00007, "R2");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, '0, "R4");
        // R7: stall with a conflicting load request
        step(0, 1, 0, 0, 17'h15555, "R7");
        step(0, 1, 1, 1, 17'h0AAAA, "R7");
        step(0, 0, 1, 1, '0, "R7");
        // R8: linear burst with order_sel toggling and stalls
        step(0, 0, 0, 0, 17'h0F00E, "R2");
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 1, (i % 2 == 0), '0, "R8");
            step(0, 1, 0, 1, 17'h1FFFF, "R7");
        end
        // R8: interleaved burst with order_sel low
        step(0, 0, 0, 1, 17'h00102, "R2");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, '0, "R8");
        // R9: reload mid-burst
        step(0, 0, 0, 0, 17'h01231, "R2");
        step(0, 0, 1, 0, '0, "R9");
        step(0, 0, 0, 0, 17'h1FFF3, "R9");
        step(0, 0, 1, 0, '0, "R9");
        step(0, 0, 1, 0, '0, "R9");
        // R1: reset mid-burst
        step(1, 0, 1, 0, '0, "R1");
        step(0, 0, 1, 0, '0, "R1");
        step(0, 1, 1, 0, '0, "R7");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule